// File: doc/BRIEF.md
# Video Memory Write Mapper

This block sits in front of three on-chip video memories: a tile pattern store, a character map and a colour palette. A 16-bit external bus writes into them only while the display pipeline is blanked. During blanking it splits the bus address into a target memory and a local word address. At all other times each memory is addressed by the pipeline's own fetch address for that memory.

Only the upper half of the bus address space is decoded, page by page, using the high byte. The decode leaves some address bits unused, so the tile store and the character map each appear at more than one bus address. Software must not rely on those aliases holding distinct data.

While forced blanking or vertical blanking is active, reads are switched off and every read port returns zero. The drawing pipeline therefore sees blank data. When blanking ends, each memory returns the word at its fetch address with one cycle of latency.

Top module: `vram_write_mapper`

## Requirements
- R1: A bus write whose address has bit 15 clear changes no memory.
- R2: Bus high bytes 0x80 to 0xBF select the tile store. The local word address is bus bits 12:0, and bit 13 is ignored, so 0xA005 writes the same word as 0x8005.
- R3: Bus high bytes 0xC0 to 0xCF select the palette. The local address is the bus low byte only.
- R4: Bus high bytes 0xE0 to 0xEF select the character map. The local address is bus bit 8 followed by the low byte, so 0xE322 and 0xE122 both write character word 0x122.
- R5: Bus high bytes 0xD0 to 0xDF and 0xF0 to 0xFF change no memory.
- R6: No memory changes in a cycle where bus_we is low.
- R7: A bus write is accepted only in a cycle where fblank or vblank is high. A write presented while both are low changes nothing.
- R8: In any cycle where fblank or vblank is high, every read data output is zero one clock later.
- R9: In a cycle where both blank flags are low, each read data output equals the word stored at that memory's fetch address one clock later. A write accepted at one edge is visible to a read at the next edge.
- R10: While rst is high, every read data output is zero from the next edge on.
- R11: The tile store holds 2**TILE_STORE_AW words (2048 by default). Local tile address bits at and above that width are dropped, so with the default 0x8805 and 0x8005 name the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | External bus address |
| bus_wdata | input | DATA_W | External bus write data |
| bus_we | input | 1 | External bus write strobe |
| fblank | input | 1 | Forced blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| tile_fetch_addr | input | TILE_AW | Pipeline tile word address |
| chr_fetch_addr | input | CHR_AW | Pipeline character word address |
| pal_fetch_addr | input | PAL_AW | Pipeline palette word address |
| tile_rdata | output | DATA_W | Registered tile read data |
| chr_rdata | output | DATA_W | Registered character read data |
| pal_rdata | output | DATA_W | Registered palette read data |

## Verification
Write effects are the hardest thing to see from the ports, because every read port is forced to zero during the only cycles in which writes can land. A missing write or a write to an aliased or undecoded page therefore cannot be seen while it happens. The stimulus writes during blanking, then drops both blank flags and steers the fetch addresses onto the words that an alias, an unused page or a low-half address could have disturbed. A behavioural model in the bench, built from associative arrays, predicts every read output each cycle.

// File: rtl/vram_map_pkg.sv
package vram_map_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_TILE = 2'd1,
    RGN_PAL  = 2'd2,
    RGN_CHR  = 2'd3
  } vram_region_e;

  // Page decode of the high byte; bit 15 must be set for any region.
  function automatic vram_region_e page_region(input logic [7:0] hi);
    vram_region_e r;
    r = RGN_NONE;
    if (hi[7]) begin
      if (!hi[6]) r = RGN_TILE;
      else begin
        case (hi[5:4])
          2'b00:   r = RGN_PAL;
          2'b10:   r = RGN_CHR;
          default: r = RGN_NONE;
        endcase
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vram_addr_decode.sv
module vram_addr_decode
  import vram_map_pkg::*;
#(
  parameter int TILE_AW = 13,
  parameter int CHR_AW  = 9,
  parameter int PAL_AW  = 8
) (
  input  logic [BUS_W-1:0]   bus_addr,
  input  logic               bus_we,
  input  logic               blank,
  output logic [TILE_AW-1:0] tile_local,
  output logic [CHR_AW-1:0]  chr_local,
  output logic [PAL_AW-1:0]  pal_local,
  output logic               tile_wsel,
  output logic               chr_wsel,
  output logic               pal_wsel
);
  vram_region_e region;
  logic         wr_ok;

  always_comb begin
    region     = page_region(bus_addr[15:8]);
    wr_ok      = bus_we && blank;
    tile_local = bus_addr[TILE_AW-1:0];
    chr_local  = bus_addr[CHR_AW-1:0];
    pal_local  = bus_addr[PAL_AW-1:0];
    tile_wsel  = wr_ok && (region == RGN_TILE);
    chr_wsel   = wr_ok && (region == RGN_CHR);
    pal_wsel   = wr_ok && (region == RGN_PAL);
  end
endmodule

// File: rtl/vram_port_sel.sv
module vram_port_sel #(
  parameter int AW = 8
) (
  input  logic          blank,
  input  logic [AW-1:0] ext_addr,
  input  logic [AW-1:0] int_addr,
  input  logic          ext_we,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic          re
);
  always_comb begin
    addr = blank ? ext_addr : int_addr;
    we   = blank && ext_we;
    re   = !blank;
  end
endmodule

// File: rtl/vram_bank.sv
module vram_bank #(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int STORE_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [DW-1:0]       mem [DEPTH];
  logic [STORE_AW-1:0] idx;

  assign idx = addr[STORE_AW-1:0];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[idx];
    else         rdata <= '0;
  end
endmodule

// File: rtl/vram_write_mapper.sv
module vram_write_mapper
  import vram_map_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int TILE_AW       = 13,
  parameter int TILE_STORE_AW = 11,
  parameter int CHR_AW        = 9,
  parameter int PAL_AW        = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               fblank,
  input  logic               vblank,
  input  logic [TILE_AW-1:0] tile_fetch_addr,
  input  logic [CHR_AW-1:0]  chr_fetch_addr,
  input  logic [PAL_AW-1:0]  pal_fetch_addr,
  output logic [DATA_W-1:0]  tile_rdata,
  output logic [DATA_W-1:0]  chr_rdata,
  output logic [DATA_W-1:0]  pal_rdata
);
  logic               blank;
  logic [TILE_AW-1:0] tile_local, tile_addr;
  logic [CHR_AW-1:0]  chr_local,  chr_addr;
  logic [PAL_AW-1:0]  pal_local,  pal_addr;
  logic tile_wsel, chr_wsel, pal_wsel;
  logic tile_we, chr_we, pal_we;
  logic tile_re, chr_re, pal_re;

  assign blank = fblank || vblank;

  vram_addr_decode #(.TILE_AW(TILE_AW), .CHR_AW(CHR_AW), .PAL_AW(PAL_AW)) u_dec (
    .bus_addr(bus_addr), .bus_we(bus_we), .blank(blank),
    .tile_local(tile_local), .chr_local(chr_local), .pal_local(pal_local),
    .tile_wsel(tile_wsel), .chr_wsel(chr_wsel), .pal_wsel(pal_wsel)
  );

  vram_port_sel #(.AW(TILE_AW)) u_tile_sel (
    .blank(blank), .ext_addr(tile_local), .int_addr(tile_fetch_addr),
    .ext_we(tile_wsel), .addr(tile_addr), .we(tile_we), .re(tile_re)
  );
  vram_port_sel #(.AW(CHR_AW)) u_chr_sel (
    .blank(blank), .ext_addr(chr_local), .int_addr(chr_fetch_addr),
    .ext_we(chr_wsel), .addr(chr_addr), .we(chr_we), .re(chr_re)
  );
  vram_port_sel #(.AW(PAL_AW)) u_pal_sel (
    .blank(blank), .ext_addr(pal_local), .int_addr(pal_fetch_addr),
    .ext_we(pal_wsel), .addr(pal_addr), .we(pal_we), .re(pal_re)
  );

  vram_bank #(.DW(DATA_W), .AW(TILE_AW), .STORE_AW(TILE_STORE_AW)) u_tile_ram (
    .clk(clk), .rst(rst), .addr(tile_addr), .we(tile_we), .re(tile_re),
    .wdata(bus_wdata), .rdata(tile_rdata)
  );
  vram_bank #(.DW(DATA_W), .AW(CHR_AW), .STORE_AW(CHR_AW)) u_chr_ram (
    .clk(clk), .rst(rst), .addr(chr_addr), .we(chr_we), .re(chr_re),
    .wdata(bus_wdata), .rdata(chr_rdata)
  );
  vram_bank #(.DW(DATA_W), .AW(PAL_AW), .STORE_AW(PAL_AW)) u_pal_ram (
    .clk(clk), .rst(rst), .addr(pal_addr), .we(pal_we), .re(pal_re),
    .wdata(bus_wdata), .rdata(pal_rdata)
  );
endmodule

// File: rtl/vram_mapper_chk.sv
module vram_mapper_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       bus_addr,
  input logic              bus_we,
  input logic              fblank,
  input logic              vblank,
  input logic              tile_we,
  input logic              chr_we,
  input logic              pal_we,
  input logic [DATA_W-1:0] tile_rdata,
  input logic [DATA_W-1:0] chr_rdata,
  input logic [DATA_W-1:0] pal_rdata
);
  // R1
  low_half_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_addr[15] |-> !(tile_we || chr_we || pal_we));

  // R5
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tile_we, chr_we, pal_we}));

  // R6 R7
  write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (tile_we || chr_we || pal_we) |-> (bus_we && (fblank || vblank)));

  // R2
  tile_page_chk: assert property (@(posedge clk) disable iff (rst)
    tile_we |-> (bus_addr[15:14] == 2'b10));

  // R3
  pal_page_chk: assert property (@(posedge clk) disable iff (rst)
    pal_we |-> (bus_addr[15:12] == 4'hC));

  // R4
  chr_page_chk: assert property (@(posedge clk) disable iff (rst)
    chr_we |-> (bus_addr[15:12] == 4'hE));

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fblank || vblank) |=> (tile_rdata == '0 && chr_rdata == '0 && pal_rdata == '0));
endmodule

bind vram_write_mapper vram_mapper_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .fblank(fblank), .vblank(vblank),
  .tile_we(tile_we), .chr_we(chr_we), .pal_we(pal_we),
  .tile_rdata(tile_rdata), .chr_rdata(chr_rdata), .pal_rdata(pal_rdata)
);

// File: tb/vram_write_mapper_test.sv
module vram_write_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TAW = 13;
  localparam int TSAW = 11;
  localparam int CAW = 9;
  localparam int PAW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [15:0]    bus_addr = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic           bus_we = 1'b0;
  logic           fblank = 1'b1;
  logic           vblank = 1'b0;
  logic [TAW-1:0] tile_fetch_addr = '0;
  logic [CAW-1:0] chr_fetch_addr = '0;
  logic [PAW-1:0] pal_fetch_addr = '0;
  logic [DW-1:0]  tile_rdata, chr_rdata, pal_rdata;

  vram_write_mapper uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .fblank(fblank), .vblank(vblank),
    .tile_fetch_addr(tile_fetch_addr), .chr_fetch_addr(chr_fetch_addr),
    .pal_fetch_addr(pal_fetch_addr),
    .tile_rdata(tile_rdata), .chr_rdata(chr_rdata), .pal_rdata(pal_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase = "R10 reset";

  // Behavioural model: one associative array per memory.
  logic [DW-1:0] m_tile [int];
  logic [DW-1:0] m_chr  [int];
  logic [DW-1:0] m_pal  [int];
  logic [DW-1:0] e_tile = '0, e_chr = '0, e_pal = '0;
  bit            v_tile = 1'b1, v_chr = 1'b1, v_pal = 1'b1;

  always @(posedge clk) begin
    int hi;
    bit blanked;
    hi = int'(bus_addr[15:8]);
    blanked = fblank || vblank;
    if (rst || blanked) begin
      e_tile <= '0; e_chr <= '0; e_pal <= '0;
      v_tile <= 1'b1; v_chr <= 1'b1; v_pal <= 1'b1;
    end else begin
      int ti;
      ti = int'(tile_fetch_addr) % (1 << TSAW);
      v_tile <= m_tile.exists(ti);
      e_tile <= m_tile.exists(ti) ? m_tile[ti] : '0;
      v_chr <= m_chr.exists(int'(chr_fetch_addr));
      e_chr <= m_chr.exists(int'(chr_fetch_addr)) ? m_chr[int'(chr_fetch_addr)] : '0;
      v_pal <= m_pal.exists(int'(pal_fetch_addr));
      e_pal <= m_pal.exists(int'(pal_fetch_addr)) ? m_pal[int'(pal_fetch_addr)] : '0;
    end
    if (!rst && blanked && bus_we) begin
      if (hi >= 'h80 && hi <= 'hBF)
        m_tile[(int'(bus_addr) % 8192) % (1 << TSAW)] = bus_wdata;
      else if (hi >= 'hC0 && hi <= 'hCF)
        m_pal[int'(bus_addr) % 256] = bus_wdata;
      else if (hi >= 'hE0 && hi <= 'hEF)
        m_chr[int'(bus_addr) % 512] = bus_wdata;
    end
  end

  task automatic cmp(input string name, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", phase, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (v_tile) cmp("tile_rdata", tile_rdata, e_tile);
    if (v_chr)  cmp("chr_rdata",  chr_rdata,  e_chr);
    if (v_pal)  cmp("pal_rdata",  pal_rdata,  e_pal);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [DW-1:0] d,
                    input bit we = 1'b1, input bit fb = 1'b1, input bit vb = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we; fblank = fb; vblank = vb;
  endtask

  task automatic rd(input int t, input int c, input int p, input int n = 2);
    @(negedge clk);
    bus_we = 1'b0; fblank = 1'b0; vblank = 1'b0;
    tile_fetch_addr = TAW'(t); chr_fetch_addr = CAW'(c); pal_fetch_addr = PAW'(p);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    phase = "R2 R3 R4 preload";
    wr(16'h8000, 16'h1111); wr(16'hE000, 16'h2222); wr(16'hC000, 16'h3333);
    wr(16'h8005, 16'hA5A5); wr(16'hC710, 16'h0C10); wr(16'hE122, 16'h0E22);
    phase = "R9 read after unblank";
    rd(5, 'h122, 'h10);
    rd(0, 0, 0);

    phase = "R2 tile alias";
    wr(16'hA005, 16'h5A5A);
    rd(5, 'h122, 'h10);

    phase = "R11 tile storage wrap";
    wr(16'h8805, 16'h7777);
    rd('h805, 'h122, 'h10);
    rd(5, 'h122, 'h10);

    phase = "R4 character alias";
    wr(16'hE322, 16'h1234);
    rd(5, 'h122, 'h10);

    phase = "R3 palette page";
    wr(16'hCF10, 16'h4321);
    rd(5, 'h122, 'h10);

    phase = "R1 low half ignored";
    wr(16'h0005, 16'hDEAD); wr(16'h4005, 16'hDEAD); wr(16'h0122, 16'hDEAD);
    wr(16'h4C10, 16'hDEAD);
    rd(5, 'h122, 'h10);

    phase = "R5 unused pages";
    wr(16'hD010, 16'hBEEF); wr(16'hF122, 16'hBEEF); wr(16'hDF05, 16'hBEEF);
    rd(5, 'h122, 'h10);

    phase = "R6 no strobe";
    wr(16'h8005, 16'hCAFE, 1'b0); wr(16'hC010, 16'hCAFE, 1'b0);
    rd(5, 'h122, 'h10);

    phase = "R7 write while drawing";
    wr(16'h8005, 16'h9999, 1'b1, 1'b0, 1'b0);
    wr(16'hE122, 16'h9999, 1'b1, 1'b0, 1'b0);
    rd(5, 'h122, 'h10);

    phase = "R8 vblank writes and zeroes";
    for (int i = 0; i < 32; i++)
      wr(16'hC000 | 16'(i), 16'(i * 3 + 1), 1'b1, 1'b0, 1'b1);
    phase = "R9 palette sweep";
    for (int i = 0; i < 32; i++) rd(i, i, i, 1);

    phase = "R8 single blank cycle";
    rd(5, 'h122, 'h10);
    wr(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0);
    rd(5, 'h122, 'h10);
    wr(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
    wr(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1);
    rd(5, 'h122, 'h10);

    phase = "R9 write then immediate read";
    wr(16'h8003, 16'h0303);
    rd(3, 0, 0, 1);

    phase = "R10 reset mid-run";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    phase = "R9 after reset";
    rd(3, 'h122, 'h10, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule